// File: doc/BRIEF.md
# Mailbox Word FIFO with Watermark Events

This block is the storage and flag engine of an inter-processor mailbox. A sending processor pushes 32-bit words into it one per cycle, and a receiving processor pops them in arrival order. Each pop reads the word at the head of the queue. The receiver normally keeps popping until the empty flag sets. A programmable watermark sets the occupancy at which the receiver should be alerted. The block reports its state through a five-bit status word and through single-cycle event pulses. A separate interrupt block latches those pulses.

The fill level is tracked by a three-state machine. The states are `FS_EMPTY` (no words held), `FS_PART` (between one word and one short of full) and `FS_FULL` (every slot holds a word). The machine moves between states on these transitions:
- `FS_EMPTY` goes to `FS_PART` when a word is accepted.
- `FS_PART` goes to `FS_FULL` when the last free slot is filled.
- `FS_PART` goes to `FS_EMPTY` when the final word is popped.
- `FS_FULL` goes to `FS_PART` when a pop is not paired with a push.
- A soft flush takes every state to `FS_EMPTY`.

Overflow and underflow are recorded in sticky status bits. A soft flush clears them, and so does the hardware reset.

Top module: `mbx_word_fifo`

## Requirements
- R1: After reset the level is 0, `status_o` is 5'b00100, every event output is 0 and the watermark holds DEPTH (32).
- R2: Words leave in the order they were accepted. While `pop_i` is high and the FIFO holds at least one word, `pop_data_o` shows the oldest word in that same cycle, and that word is removed at the clock edge.
- R3: A push while the FIFO is full, without a pop in the same cycle, is discarded and the stored words are kept. The same edge sets sticky status bit 4 and pulses event bit 4.
- R4: A pop while the FIFO is empty returns zero on `pop_data_o`. The same edge sets sticky status bit 3 and pulses event bit 5.
- R5: A push and a pop in the same cycle leave the level unchanged when the FIFO is not empty, and no overflow is recorded even when it is full. When it is empty, the pop counts as an underflow and the pushed word is stored, so the level becomes 1.
- R6: A control write with data bit 0 set empties the FIFO and clears both sticky bits, but leaves the watermark as it was. That cycle's push and pop are dropped and no event pulses. A control write with bit 0 clear changes nothing.
- R7: Status bit 0 is 1 exactly when the level is greater than or equal to the watermark. A watermark write takes effect at the next edge.
- R8: Event bit 2 pulses for one cycle when (level >= watermark) goes from false to true. Event bit 3 pulses for one cycle on the opposite change.
- R9: Event bit 0 pulses when the level reaches DEPTH. Event bit 1 pulses when a pop takes the level to 0. Event bit 6 pulses when the level leaves 0.
- R10: Status bit 1 is full (level equals DEPTH) and status bit 2 is empty (level is 0). All status bits, the level and the events update at the same clock edge that registers the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request for the write-data word |
| push_data_i | input | 32 | Word to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 32 | Head word, or zero when empty |
| wm_we_i | input | 1 | Watermark write strobe |
| wm_data_i | input | 6 | New watermark value |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_data_i | input | 32 | Control data; bit 0 requests a flush |
| level_o | output | 6 | Current occupancy |
| status_o | output | 5 | {overflow, underflow, empty, full, watermark reached} |
| evt_o | output | 7 | Event pulses; bit k maps to interrupt bit k+2 |

## Verification
`pop_data_o` is combinational, so the bench reads it one time step after it drives `pop_i`. That read happens in the same cycle as the request. Level, status and events are all registered, so each operation shows on them at the first clock edge after it is driven. The bench drives inputs at the falling edge. At the next falling edge it compares those registered outputs against a queue-based model that it advanced in step with that edge. This gives exactly one edge of latency for every result.

// File: rtl/mbx_fifo_pkg.sv
package mbx_fifo_pkg;
    localparam int STS_WM    = 0;
    localparam int STS_FULL  = 1;
    localparam int STS_EMPTY = 2;
    localparam int STS_UDF   = 3;
    localparam int STS_OVF   = 4;
    localparam int STS_W     = 5;

    localparam int EV_FULL   = 0;
    localparam int EV_EMPTY  = 1;
    localparam int EV_WMRISE = 2;
    localparam int EV_WMFALL = 3;
    localparam int EV_OVF    = 4;
    localparam int EV_UDF    = 5;
    localparam int EV_NEMPTY = 6;
    localparam int EV_W      = 7;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/mbx_fifo_store.sv
module mbx_fifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en_i && !flush_i) begin
            mem[wr_ptr] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en_i) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en_i) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    assign rd_data_o = mem[rd_ptr];
endmodule

// File: rtl/mbx_fifo_ctrl.sv
module mbx_fifo_ctrl
    import mbx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic          pop_i,
    output fill_state_e   state_o,
    output logic [CW-1:0] level_o,
    output logic [CW-1:0] level_nxt_o,
    output logic          do_push_o,
    output logic          do_pop_o,
    output logic          ovf_ev_o,
    output logic          udf_ev_o
);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_LAST = CW'(DEPTH - 1);

    fill_state_e   state_q, state_d;
    logic [CW-1:0] level_q, level_d;
    logic          pop_ok, push_ok;

    always_comb begin
        pop_ok    = pop_i && (state_q != FS_EMPTY);
        push_ok   = push_i && ((state_q != FS_FULL) || pop_ok);
        do_pop_o  = pop_ok && !flush_i;
        do_push_o = push_ok && !flush_i;
        ovf_ev_o  = !flush_i && push_i && !push_ok;
        udf_ev_o  = !flush_i && pop_i && (state_q == FS_EMPTY);
        if (flush_i) begin
            level_d = '0;
        end else begin
            level_d = level_q + CW'(do_push_o) - CW'(do_pop_o);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_EMPTY: begin
                if (do_push_o) state_d = FS_PART;
            end
            FS_PART: begin
                if (do_push_o && !do_pop_o && level_q == LVL_LAST) begin
                    state_d = FS_FULL;
                end else if (do_pop_o && !do_push_o && level_q == CW'(1)) begin
                    state_d = FS_EMPTY;
                end
            end
            FS_FULL: begin
                if (do_pop_o && !do_push_o) state_d = FS_PART;
            end
            default: state_d = FS_EMPTY;
        endcase
        if (flush_i) state_d = FS_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_EMPTY;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    assign state_o     = state_q;
    assign level_o     = level_q;
    assign level_nxt_o = level_d;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == LVL_FULL && push_i && !pop_i && !flush_i) |=> (level_q == LVL_FULL))
        else $error("R3: level moved on a push into a full FIFO");

    p_pair_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && level_q != '0) |=> $stable(level_q))
        else $error("R5: paired push and pop changed the level");

    p_state_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_EMPTY) == (level_q == '0)) && ((state_q == FS_FULL) == (level_q == LVL_FULL)))
        else $error("R10: fill state disagrees with level");

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_q == '0 && state_q == FS_EMPTY))
        else $error("R6: flush left words behind");
endmodule

// File: rtl/mbx_fifo_mon.sv
module mbx_fifo_mon
    import mbx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            wm_we_i,
    input  logic [CW-1:0]   wm_data_i,
    input  logic [CW-1:0]   level_i,
    input  logic [CW-1:0]   level_nxt_i,
    input  logic            ovf_ev_i,
    input  logic            udf_ev_i,
    output logic            wm_hit_o,
    output logic            ovf_o,
    output logic            udf_o,
    output logic [EV_W-1:0] evt_o
);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

    logic [CW-1:0]   wm_q, wm_d;
    logic            ovf_q, udf_q;
    logic [EV_W-1:0] evt_q, evt_d;
    logic            hit_now, hit_nxt;

    always_comb begin
        wm_d    = wm_we_i ? wm_data_i : wm_q;
        hit_now = level_i >= wm_q;
        hit_nxt = level_nxt_i >= wm_d;
        evt_d   = '0;
        if (!flush_i) begin
            evt_d[EV_FULL]   = (level_nxt_i == LVL_FULL) && (level_i != LVL_FULL);
            evt_d[EV_EMPTY]  = (level_nxt_i == '0) && (level_i != '0);
            evt_d[EV_NEMPTY] = (level_nxt_i != '0) && (level_i == '0);
            evt_d[EV_WMRISE] = !hit_now && hit_nxt;
            evt_d[EV_WMFALL] = hit_now && !hit_nxt;
            evt_d[EV_OVF]    = ovf_ev_i;
            evt_d[EV_UDF]    = udf_ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wm_q  <= LVL_FULL;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
            evt_q <= '0;
        end else begin
            wm_q  <= wm_d;
            evt_q <= evt_d;
            if (flush_i) begin
                ovf_q <= 1'b0;
                udf_q <= 1'b0;
            end else begin
                ovf_q <= ovf_q | ovf_ev_i;
                udf_q <= udf_q | udf_ev_i;
            end
        end
    end

    assign wm_hit_o = hit_now;
    assign ovf_o    = ovf_q;
    assign udf_o    = udf_q;
    assign evt_o    = evt_q;

    p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flush_i) |=> ovf_q)
        else $error("R3: overflow flag dropped without flush");

    p_sticky_udf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_q && !flush_i) |=> udf_q)
        else $error("R4: underflow flag dropped without flush");

    p_wm_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_q[EV_WMRISE], evt_q[EV_WMFALL]}))
        else $error("R8: rise and fall pulsed together");
endmodule

// File: rtl/mbx_word_fifo.sv
module mbx_word_fifo
    import mbx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DW-1:0]     push_data_i,
    input  logic              pop_i,
    output logic [DW-1:0]     pop_data_o,
    input  logic              wm_we_i,
    input  logic [CW-1:0]     wm_data_i,
    input  logic              ctrl_we_i,
    input  logic [31:0]       ctrl_data_i,
    output logic [CW-1:0]     level_o,
    output logic [STS_W-1:0]  status_o,
    output logic [EV_W-1:0]   evt_o
);
    fill_state_e   state;
    logic [CW-1:0] level, level_nxt;
    logic          flush, do_push, do_pop, ovf_ev, udf_ev;
    logic          wm_hit, ovf, udf;
    logic [DW-1:0] head;

    assign flush = ctrl_we_i && ctrl_data_i[0];

    mbx_fifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .state_o     (state),
        .level_o     (level),
        .level_nxt_o (level_nxt),
        .do_push_o   (do_push),
        .do_pop_o    (do_pop),
        .ovf_ev_o    (ovf_ev),
        .udf_ev_o    (udf_ev)
    );

    mbx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .wr_en_i   (do_push),
        .wr_data_i (push_data_i),
        .rd_en_i   (do_pop),
        .rd_data_o (head)
    );

    mbx_fifo_mon #(.DEPTH(DEPTH), .CW(CW)) i_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .wm_we_i     (wm_we_i),
        .wm_data_i   (wm_data_i),
        .level_i     (level),
        .level_nxt_i (level_nxt),
        .ovf_ev_i    (ovf_ev),
        .udf_ev_i    (udf_ev),
        .wm_hit_o    (wm_hit),
        .ovf_o       (ovf),
        .udf_o       (udf),
        .evt_o       (evt_o)
    );

    always_comb begin
        status_o            = '0;
        status_o[STS_WM]    = wm_hit;
        status_o[STS_FULL]  = (state == FS_FULL);
        status_o[STS_EMPTY] = (state == FS_EMPTY);
        status_o[STS_UDF]   = udf;
        status_o[STS_OVF]   = ovf;
        pop_data_o          = (state == FS_EMPTY) ? '0 : head;
    end

    assign level_o = level;

    p_udf_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush && level == '0) |=> (evt_o[EV_UDF] && status_o[STS_UDF]))
        else $error("R4: empty pop not reported");
endmodule

// File: tb/test_mbx_word_fifo.sv
module test_mbx_word_fifo;
    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, wm_we_i = 1'b0, ctrl_we_i = 1'b0;
    logic [31:0] push_data_i = '0, ctrl_data_i = '0;
    logic [5:0]  wm_data_i = '0;
    logic [31:0] pop_data_o;
    logic [5:0]  level_o;
    logic [4:0]  status_o;
    logic [6:0]  evt_o;

    int errors = 0;
    int checks = 0;

    int unsigned q[$];
    int  m_wm = D;
    bit  m_ovf = 0, m_udf = 0;
    logic [6:0] m_evt = '0;
    string last_tag = "R1";
    int unsigned seed_word = 32'h1000;

    always #4 clk = ~clk;

    mbx_word_fifo i_mbx_word_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o),
        .wm_we_i(wm_we_i), .wm_data_i(wm_data_i),
        .ctrl_we_i(ctrl_we_i), .ctrl_data_i(ctrl_data_i),
        .level_o(level_o), .status_o(status_o), .evt_o(evt_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_regs(input string tag);
        logic [4:0] es;
        es = {m_ovf, m_udf, q.size() == 0, q.size() == D, q.size() >= m_wm};
        check(tag, "level (R2)", level_o, q.size());
        check(tag, "status wm (R7)", status_o[0], es[0]);
        check(tag, "status full/empty (R10)", status_o[2:1], es[2:1]);
        check(tag, "status underflow (R4)", status_o[3], es[3]);
        check(tag, "status overflow (R3)", status_o[4], es[4]);
        check(tag, "events fill (R9)", {evt_o[6], evt_o[1:0]}, {m_evt[6], m_evt[1:0]});
        check(tag, "events watermark (R8)", evt_o[3:2], m_evt[3:2]);
        check(tag, "events ovf/udf", evt_o[5:4], m_evt[5:4]);
    endtask

    task automatic step(input string tag, input bit pu, input bit po,
                        input bit wwe = 0, input int wd = 0,
                        input bit cwe = 0, input logic [31:0] cd = '0);
        int old_n, new_n, wm_new;
        bit pop_ok, push_ok, flush;
        logic [31:0] d;
        @(negedge clk);
        compare_regs(last_tag);
        d = seed_word;
        seed_word = seed_word + 32'h11;
        push_i = pu; push_data_i = d; pop_i = po;
        wm_we_i = wwe; wm_data_i = 6'(wd);
        ctrl_we_i = cwe; ctrl_data_i = cd;
        #1;
        if (po) check(tag, "pop data (R2/R4)", pop_data_o, (q.size() > 0) ? q[0] : 0);
        flush = cwe && cd[0];
        old_n = q.size();
        wm_new = wwe ? wd : m_wm;
        m_evt = '0;
        if (flush) begin
            q.delete();
            m_ovf = 0; m_udf = 0;
        end else begin
            pop_ok = po && old_n > 0;
            push_ok = pu && (old_n < D || pop_ok);
            if (pu && !push_ok) begin m_evt[4] = 1; m_ovf = 1; end
            if (po && old_n == 0) begin m_evt[5] = 1; m_udf = 1; end
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(d);
            new_n = q.size();
            m_evt[0] = (new_n == D) && (old_n != D);
            m_evt[1] = (new_n == 0) && (old_n != 0);
            m_evt[6] = (new_n != 0) && (old_n == 0);
            m_evt[2] = !(old_n >= m_wm) && (new_n >= wm_new);
            m_evt[3] = (old_n >= m_wm) && !(new_n >= wm_new);
        end
        m_wm = wm_new;
        last_tag = tag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "level", level_o, 0);
        check("R1", "status", status_o, 5'b00100);
        check("R1", "events", evt_o, 0);
        // R2: ordering
        for (int i = 0; i < 3; i++) step("R2", 1, 0);
        for (int i = 0; i < 3; i++) step("R2", 0, 1);
        // R4: underflow on empty pop
        step("R4", 0, 1);
        step("R4", 0, 0);
        // R6: control bit 0 clear does nothing, then flush
        step("R6", 1, 0);
        step("R6", 0, 0, 0, 0, 1, 32'hFFFF_FFFE);
        step("R6", 0, 0, 0, 0, 1, 32'h1);
        step("R6", 0, 0);
        // R7/R8: watermark at 4
        step("R7", 0, 0, 1, 4);
        for (int i = 0; i < 5; i++) step("R8", 1, 0);
        for (int i = 0; i < 2; i++) step("R8", 0, 1);
        step("R8", 0, 0, 1, 2);
        step("R8", 0, 0, 1, 6);
        // R5: paired push/pop mid-level
        step("R5", 1, 1);
        step("R5", 1, 1);
        // R9/R3: fill, overflow, paired at full
        step("R7", 0, 0, 1, 32);
        while (q.size() < D) step("R9", 1, 0);
        step("R3", 1, 0);
        step("R3", 1, 0);
        step("R5", 1, 1);
        step("R3", 0, 0);
        while (q.size() > 0) step("R9", 0, 1);
        // R5: paired on empty
        step("R5", 1, 1);
        step("R5", 0, 0);
        // R6: flush with words held and a push in the same cycle
        step("R6", 1, 0);
        step("R6", 1, 1, 0, 0, 1, 32'h1);
        step("R10", 0, 0);
        step("R10", 0, 0);
        @(negedge clk);
        compare_regs(last_tag);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule